// File: doc/BRIEF.md
# Serial Status Flag Controller

This block keeps the three status flags of a synchronous serial unit: transmit-end, transmit-data-empty and receive-data-full. It sits between a CPU register bus and the serial engine. The CPU sees the flags through one status register and can clear a flag only by a write of 0 that follows a read in which that flag was seen as 1. The serial engine reports its progress as single-cycle events and one level. These are a word loaded into the shift register, the last bit shifted out, a completed received word, and the transmit-enable level.

Accesses to the data registers also clear flags. A write of the transmit data register clears transmit-end, and clears transmit-data-empty while transmission is enabled. A read of the receive data register clears receive-data-full. The transmit-end flag has two set timings, chosen by a select input. It can set at the last-bit event itself, or a parameterised number of serial bit periods later, counted on a bit-period tick. Each flag drives a level interrupt request, masked by its own enable.

Top module: `ser_flag_ctrl`

## Requirements
- R1: After reset the status readback is 8'h0C. Transmit-end is at bit 3 (1), transmit-data-empty at bit 2 (1) and receive-data-full at bit 1 (0). All other readback bits are always 0.
- R2: Transmit-data-empty is 1 in the cycle after any cycle in which `txEnable` is 0, and in the cycle after a `txLoad` pulse.
- R3: A `txDataWr` pulse with `txEnable` at 1 clears transmit-data-empty on the next cycle. With `txEnable` at 0 it leaves the flag at 1.
- R4: With `endLate` at 0, a `txLastBit` pulse sets transmit-end on the next cycle, but only if transmit-data-empty is 1 in that cycle.
- R5: With `endLate` at 1, a `txLastBit` pulse taken while transmit-data-empty is 1 starts a wait. Transmit-end sets in the cycle after the DELAY_TICKS-th following `bitTick` pulse. A `txDataWr` during the wait cancels it.
- R6: A `txDataWr` pulse clears transmit-end on the next cycle, whatever the state of `txEnable`.
- R7: An `rxDone` pulse sets receive-data-full on the next cycle, and an `rxDataRd` pulse clears it.
- R8: A `regWr` with 0 at a flag's bit position clears that flag only if a `regRd` has seen the flag as 1 since the previous `regWr`. Every `regWr` disarms all flags. Writing 1 at a flag's position never changes it, and a read that sees 0 does not arm the flag.
- R9: When a hardware set event and any clear for the same flag fall in one cycle, the flag is 1 afterwards.
- R10: `irqReq` bit 2, bit 1 and bit 0 are transmit-end, transmit-data-empty and receive-data-full. Each is ANDed with the matching bit of `irqEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regRd | input | 1 | Status register read strobe |
| regWr | input | 1 | Status register write strobe |
| regWdata | input | DATA_W | Status register write data |
| regRdata | output | DATA_W | Status register readback (current flags) |
| txDataWr | input | 1 | CPU write of the transmit data register |
| rxDataRd | input | 1 | CPU read of the receive data register |
| txEnable | input | 1 | Transmit enable level |
| txLoad | input | 1 | Transmit word moved into the shift register |
| txLastBit | input | 1 | Last transmit bit shifted out |
| rxDone | input | 1 | Received word moved to the receive data register |
| bitTick | input | 1 | One pulse per serial bit period |
| endLate | input | 1 | Transmit-end timing select (0 at event, 1 delayed) |
| irqEn | input | 3 | Interrupt enables {end, empty, full} |
| irqReq | output | 3 | Level interrupt requests {end, empty, full} |

## Verification
The bench builds the block with DELAY_TICKS = 2. With that value the delayed transmit-end window has an intermediate tick at which the flag must still be 0. That window can also be cancelled between its two ticks. The arm-and-clear protocol is swept over every flag, with the arming read present or absent and with a 0 or a 1 written. The interrupt mask is swept over all eight enable patterns for two different flag states.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int NFLAG     = 3;
  localparam int IDX_FULL  = 0;
  localparam int IDX_EMPTY = 1;
  localparam int IDX_END   = 2;

  typedef struct packed {
    logic [NFLAG-1:0] hwSet;
    logic [NFLAG-1:0] hwClr;
    logic [NFLAG-1:0] cpuZero;
    logic             cpuRd;
    logic             cpuWr;
  } flagStrobe_t;
endpackage

// File: rtl/sfc_ctrl.sv
module sfc_ctrl
  import sfc_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int END_POS     = 3,
  parameter int EMPTY_POS   = 2,
  parameter int FULL_POS    = 1,
  parameter int DELAY_TICKS = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              txDataWr,
  input  logic              rxDataRd,
  input  logic              txEnable,
  input  logic              txLoad,
  input  logic              txLastBit,
  input  logic              rxDone,
  input  logic              bitTick,
  input  logic              endLate,
  input  logic              emptyNow,
  output flagStrobe_t       stb
);
  localparam int CNT_W = (DELAY_TICKS > 1) ? $clog2(DELAY_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DELAY_TICKS - 1);
  localparam int FLAG_POS [NFLAG] = '{FULL_POS, EMPTY_POS, END_POS};

  logic             latePending;
  logic [CNT_W-1:0] tickCnt;
  logic             lateStart;
  logic             lateFire;
  logic             immSet;

  assign immSet    = txLastBit & ~endLate & emptyNow;
  assign lateStart = txLastBit &  endLate & emptyNow;
  assign lateFire  = latePending & bitTick & (tickCnt == LAST_CNT);

  // delayed transmit-end window: counts bit ticks after the last-bit event
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latePending <= 1'b0;
      tickCnt     <= '0;
    end else if (lateStart) begin
      latePending <= 1'b1;
      tickCnt     <= '0;
    end else if (txDataWr || lateFire) begin
      latePending <= 1'b0;
      tickCnt     <= '0;
    end else if (latePending && bitTick) begin
      tickCnt     <= tickCnt + 1'b1;
    end
  end

  always_comb begin
    stb       = '0;
    stb.cpuRd = regRd;
    stb.cpuWr = regWr;
    for (int i = 0; i < NFLAG; i++) begin
      stb.cpuZero[i] = ~regWdata[FLAG_POS[i]];
    end
    stb.hwSet[IDX_END]   = immSet | (lateFire & emptyNow);
    stb.hwClr[IDX_END]   = txDataWr;
    stb.hwSet[IDX_EMPTY] = ~txEnable | txLoad;
    stb.hwClr[IDX_EMPTY] = txDataWr & txEnable;
    stb.hwSet[IDX_FULL]  = rxDone;
    stb.hwClr[IDX_FULL]  = rxDataRd;
  end

  logic unusedWdata;
  assign unusedWdata = ^regWdata;
endmodule

// File: rtl/sfc_dpath.sv
module sfc_dpath
  import sfc_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int END_POS   = 3,
  parameter int EMPTY_POS = 2,
  parameter int FULL_POS  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  flagStrobe_t       stb,
  input  logic [NFLAG-1:0]  irqEn,
  output logic [NFLAG-1:0]  flags,
  output logic [DATA_W-1:0] regRdata,
  output logic [NFLAG-1:0]  irqReq
);
  localparam int FLAG_POS [NFLAG] = '{FULL_POS, EMPTY_POS, END_POS};
  localparam logic [NFLAG-1:0] RST_VAL =
    NFLAG'((1 << IDX_END) | (1 << IDX_EMPTY));

  logic [NFLAG-1:0] armQ;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    logic cpuClr;
    assign cpuClr = stb.cpuWr & stb.cpuZero[g] & armQ[g];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        flags[g] <= RST_VAL[g];
      end else if (stb.hwSet[g]) begin
        flags[g] <= 1'b1;
      end else if (stb.hwClr[g] || cpuClr) begin
        flags[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        armQ[g] <= 1'b0;
      end else if (stb.cpuWr) begin
        armQ[g] <= 1'b0;
      end else if (stb.cpuRd && flags[g]) begin
        armQ[g] <= 1'b1;
      end
    end
  end

  always_comb begin
    regRdata = '0;
    for (int i = 0; i < NFLAG; i++) begin
      regRdata[FLAG_POS[i]] = flags[i];
    end
  end

  assign irqReq = flags & irqEn;
endmodule

// File: rtl/ser_flag_ctrl.sv
module ser_flag_ctrl
  import sfc_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int END_POS     = 3,
  parameter int EMPTY_POS   = 2,
  parameter int FULL_POS    = 1,
  parameter int DELAY_TICKS = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              txDataWr,
  input  logic              rxDataRd,
  input  logic              txEnable,
  input  logic              txLoad,
  input  logic              txLastBit,
  input  logic              rxDone,
  input  logic              bitTick,
  input  logic              endLate,
  input  logic [2:0]        irqEn,
  output logic [2:0]        irqReq
);
  flagStrobe_t      stb;
  logic [NFLAG-1:0] flags;

  sfc_ctrl #(
    .DATA_W(DATA_W), .END_POS(END_POS), .EMPTY_POS(EMPTY_POS),
    .FULL_POS(FULL_POS), .DELAY_TICKS(DELAY_TICKS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regRd(regRd), .regWr(regWr),
    .regWdata(regWdata), .txDataWr(txDataWr), .rxDataRd(rxDataRd),
    .txEnable(txEnable), .txLoad(txLoad), .txLastBit(txLastBit),
    .rxDone(rxDone), .bitTick(bitTick), .endLate(endLate),
    .emptyNow(flags[IDX_EMPTY]), .stb(stb)
  );

  sfc_dpath #(
    .DATA_W(DATA_W), .END_POS(END_POS), .EMPTY_POS(EMPTY_POS),
    .FULL_POS(FULL_POS)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .irqEn(irqEn),
    .flags(flags), .regRdata(regRdata), .irqReq(irqReq)
  );
endmodule

// File: rtl/ser_flag_chk.sv
module ser_flag_chk #(
  parameter int DATA_W    = 8,
  parameter int END_POS   = 3,
  parameter int EMPTY_POS = 2,
  parameter int FULL_POS  = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWr,
  input logic [DATA_W-1:0] regWdata,
  input logic [DATA_W-1:0] regRdata,
  input logic              txDataWr,
  input logic              rxDataRd,
  input logic              txEnable,
  input logic              txLoad,
  input logic              txLastBit,
  input logic              rxDone,
  input logic              bitTick,
  input logic              endLate,
  input logic [2:0]        irqEn,
  input logic [2:0]        irqReq
);
  logic endF, emptyF, fullF;
  assign endF   = regRdata[END_POS];
  assign emptyF = regRdata[EMPTY_POS];
  assign fullF  = regRdata[FULL_POS];

  p_empty_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |=> emptyF);

  p_empty_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (txDataWr && txEnable && !txLoad) |=> !emptyF);

  p_end_now_r4: assert property (@(posedge clk) disable iff (!rstN)
    (txLastBit && !endLate && emptyF) |=> endF);

  p_end_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (txDataWr && !txLastBit && !bitTick) |=> !endF);

  p_full_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> fullF);

  p_one_keeps_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regWdata[FULL_POS] && !rxDataRd && fullF) |=> fullF);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    (txLoad && txDataWr && txEnable) |=> emptyF);

  p_irq_mask_r10: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq & ~irqEn) == 3'b000);

  logic unusedRdata;
  assign unusedRdata = ^regRdata;
endmodule

bind ser_flag_ctrl ser_flag_chk #(
  .DATA_W(DATA_W), .END_POS(END_POS), .EMPTY_POS(EMPTY_POS), .FULL_POS(FULL_POS)
) u_chk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regWdata(regWdata),
  .regRdata(regRdata), .txDataWr(txDataWr), .rxDataRd(rxDataRd),
  .txEnable(txEnable), .txLoad(txLoad), .txLastBit(txLastBit),
  .rxDone(rxDone), .bitTick(bitTick), .endLate(endLate),
  .irqEn(irqEn), .irqReq(irqReq)
);

// File: tb/test_ser_flag_ctrl.sv
`timescale 1ns/1ps
module test_ser_flag_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regRd = 0, regWr = 0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       txDataWr = 0, rxDataRd = 0, txEnable = 0, txLoad = 0;
  logic       txLastBit = 0, rxDone = 0, bitTick = 0, endLate = 0;
  logic [2:0] irqEn = '0;
  logic [2:0] irqReq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ser_flag_ctrl #(.DELAY_TICKS(2)) i_ser_flag_ctrl (
    .clk(clk), .rstN(rstN), .regRd(regRd), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata), .txDataWr(txDataWr),
    .rxDataRd(rxDataRd), .txEnable(txEnable), .txLoad(txLoad),
    .txLastBit(txLastBit), .rxDone(rxDone), .bitTick(bitTick),
    .endLate(endLate), .irqEn(irqEn), .irqReq(irqReq)
  );

  function automatic logic [7:0] img(input bit e, input bit m, input bit f);
    return {4'b0, e, m, f, 1'b0};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clearIn();
    regRd = 0; regWr = 0; regWdata = '0; txDataWr = 0; rxDataRd = 0;
    txLoad = 0; txLastBit = 0; rxDone = 0; bitTick = 0;
  endtask

  task automatic pTxWr();   txDataWr = 1;  step(); clearIn(); endtask
  task automatic pLoad();   txLoad = 1;    step(); clearIn(); endtask
  task automatic pLast();   txLastBit = 1; step(); clearIn(); endtask
  task automatic pTick();   bitTick = 1;   step(); clearIn(); endtask
  task automatic pRxDone(); rxDone = 1;    step(); clearIn(); endtask
  task automatic pRxRd();   rxDataRd = 1;  step(); clearIn(); endtask
  task automatic pRead();   regRd = 1;     step(); clearIn(); endtask
  task automatic pWrite(input logic [7:0] d);
    regWr = 1; regWdata = d; step(); clearIn();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    step();
    chk("R1 reset image", regRdata, 8'h0C);
    irqEn = 3'b111;
    #1 chk("R10 irq after reset", {5'b0, irqReq}, 8'h06);
    irqEn = 3'b000;

    // R3: transmit data write with enable low leaves empty set
    pTxWr();
    chk("R3 ignored when disabled", regRdata, img(0, 1, 0));
    txEnable = 1; step();
    chk("R2 still empty after enable", regRdata, img(0, 1, 0));
    pLast();
    chk("R4 immediate set", regRdata, img(1, 1, 0));
    pTxWr();
    chk("R3 R6 data write clears", regRdata, img(0, 0, 0));
    pLast();
    chk("R4 no set when not empty", regRdata, img(0, 0, 0));
    pLoad();
    chk("R2 load sets empty", regRdata, img(0, 1, 0));
    pTxWr(); pLoad();
    txEnable = 0; pTxWr(); txEnable = 1;
    chk("R6 end clear with enable low", regRdata, img(0, 1, 0));

    // R5 delayed set, two ticks
    pLast();
    pTxWr(); pLoad(); pLast();
    chk("R4 immediate again", regRdata, img(1, 1, 0));
    pTxWr(); pLoad();
    endLate = 1;
    pLast();
    chk("R5 not set at event", regRdata, img(0, 1, 0));
    pTick();
    chk("R5 not set after first tick", regRdata, img(0, 1, 0));
    pTick();
    chk("R5 set after second tick", regRdata, img(1, 1, 0));
    // R5 cancel
    pTxWr(); pLoad(); pLast(); pTick();
    pTxWr(); pLoad(); pTick(); pTick();
    chk("R5 cancelled by data write", regRdata, img(0, 1, 0));
    endLate = 0;

    // R7
    pRxDone();
    chk("R7 receive sets full", regRdata, img(0, 1, 1));
    pRxRd();
    chk("R7 data read clears full", regRdata, img(0, 1, 0));

    // R8 sweep: flag x arming read x written bit value
    for (int f = 0; f < 3; f++) begin
      for (int arm = 0; arm < 2; arm++) begin
        for (int wb = 0; wb < 2; wb++) begin
          int pos;
          logic [7:0] d;
          pos = f + 1;
          if (f == 0) pRxDone();
          else if (f == 1) pLoad();
          else begin pLoad(); pLast(); end
          if (arm == 1) pRead();
          d = 8'hFF;
          d[pos] = wb[0];
          pWrite(d);
          chk($sformatf("R8 flag%0d arm%0d wbit%0d", f, arm, wb),
              {7'b0, regRdata[pos]},
              {7'b0, !(arm == 1 && wb == 0)});
        end
      end
    end
    // R8: a write of 1 disarms; a later write of 0 has no effect
    pRxDone(); pRead(); pWrite(8'hFF); pWrite(8'h00);
    chk("R8 disarmed by earlier write", {7'b0, regRdata[1]}, 8'h01);
    // R8: a read that sees 0 does not arm
    pRxRd(); pRead(); pRxDone(); pWrite(8'h00);
    chk("R8 read of 0 does not arm", {7'b0, regRdata[1]}, 8'h01);

    // R9 set wins
    rxDone = 1; rxDataRd = 1; step(); clearIn();
    chk("R9 receive beats data read", {7'b0, regRdata[1]}, 8'h01);
    pRead();
    rxDone = 1; regWr = 1; regWdata = 8'h00; step(); clearIn();
    chk("R9 receive beats cpu clear", {7'b0, regRdata[1]}, 8'h01);
    txLoad = 1; txDataWr = 1; step(); clearIn();
    chk("R9 load beats data write", {7'b0, regRdata[2]}, 8'h01);

    // R10 sweep over enables for two flag states
    for (int s = 0; s < 2; s++) begin
      bit fe, fm, ff;
      if (s == 0) begin pTxWr(); pRxDone(); end
      else begin pRxRd(); pLoad(); pLast(); end
      fe = regRdata[3]; fm = regRdata[2]; ff = regRdata[1];
      chk($sformatf("R10 state%0d setup", s), regRdata,
          (s == 0) ? img(0, 0, 1) : img(1, 1, 0));
      for (int e = 0; e < 8; e++) begin
        irqEn = e[2:0];
        #1;
        chk($sformatf("R10 state%0d en%0d", s, e), {5'b0, irqReq},
            {5'b0, e[2] & fe, e[1] & fm, e[0] & ff});
      end
      irqEn = 3'b000;
      step();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule